// File: doc/BRIEF.md
# Boot-configured memory base address register

This block is one 32-bit memory-space base address register of a configuration header. Its shape is not fixed when the chip is built. It takes its shape from a configuration word that arrives after reset from external boot memory. That word decides four things:

- which address bits software may program;
- whether the region reports itself as prefetchable;
- whether the region must sit below the first megabyte;
- the width of the add-on bus behind the region, or that the region is switched off.

Until that word is latched, the region stays switched off.

Host software sees the usual sizing behaviour. It writes all ones and reads back the value, and the zero bits give the region size. It then programs a base address. Configuration writes carry byte enables. The block also compares every incoming 32-bit address against the programmed base and raises a hit flag for addresses inside the region.

One instance can be marked as the first register of the header. For that instance the writable mask is a build-time constant, and the prefetch and below-1MB flags always read as zero.

Top module: `bar_mem_region`

## Requirements
- R1: After reset, and before any boot strobe, `cfg_rdata` reads 0, `addr_hit` is 0, `region_en` is 0 and `bus_width` is 2'b00.
- R2: A one-cycle `boot_load` pulse latches `boot_word` at that clock edge. Its effect is visible on the outputs from the following cycle.
- R3: `boot_word[31:30]` selects the add-on bus width and is driven out on `bus_width`. 2'b01 means 8 bits, 2'b10 means 16 bits and 2'b11 means 32 bits. 2'b00 switches the region off. `region_en` is 1 exactly when a word with a non-zero code has been latched.
- R4: While the region is off, `cfg_rdata` reads all zeros and `addr_hit` stays 0, whatever address is presented.
- R5: For an ordinary instance the writable mask is built from the boot word. Mask bits 29:4 equal `boot_word[29:4]`. Mask bits 31:30 both copy `boot_word[29]`. Mask bits 3:0 are 0.
- R6: A configuration write changes only the bytes whose `cfg_be` bit is 1, where `cfg_be[i]` covers data bits 8i+7:8i. Within an enabled byte, only the bits set in the mask take the written value.
- R7: The read value carries the stored base in bits 31:4. For an ordinary instance it also carries the prefetch flag `boot_word[3]` in bit 3 and the below-1MB type flag `boot_word[1]` in bit 1. Bits 2 and 0 always read 0, and writes never change bits 3:0.
- R8: On an instance built with `IS_REG0=1`, the mask equals the parameter `REG0_MASK`, and bits 3:1 read 0 whatever the boot word holds.
- R9: `addr_hit` is 1 exactly when the region is on and `probe_addr` AND mask equals the stored base AND mask.
- R10: Every boot strobe clears the stored base to zero, so the base must be reprogrammed after each reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_load | input | 1 | One-cycle strobe that latches the boot word |
| boot_word | input | 32 | Configuration word from boot memory |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Composed register read value |
| probe_addr | input | 32 | Address to decode against the region |
| addr_hit | output | 1 | Address falls inside the enabled region |
| region_en | output | 1 | Region is enabled |
| bus_width | output | 2 | Add-on bus width code |

## Verification
The register is loaded with several boot words:

- One with a contiguous 4 KB mask and both flags set. This shows that the flags are routed separately from the address bits.
- One whose bit 29 fans out into the top mask bits. This separates the bit-copy rule from a plain copy of the word.
- One with a mask that has gaps. This shows that masking is done per bit and not as a contiguous size.
- One with a zero width code. This shows that a switched-off region hides its state.

Writes use partial byte-enable patterns, so a wrong byte lane is caught. Probe addresses differ from the base only above or only below the mask boundary, which separates a correct compare from one that ignores the mask. A second instance marked as the first register is loaded with an all-ones word, so it must ignore the word's flags and mask.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int BAR_W  = 32;
  localparam int NBYTES = BAR_W / 8;
  localparam int LOW_W  = 4;

  typedef enum logic [1:0] {
    BW_OFF = 2'b00,
    BW_8   = 2'b01,
    BW_16  = 2'b10,
    BW_32  = 2'b11
  } bw_code_e;

  typedef struct packed {
    logic [BAR_W-1:0] mask;
    logic             pf;
    logic             mtype;
    bw_code_e         width;
  } bar_cfg_t;

  // Writable mask from the boot word: bit 29 is copied into the two top bits.
  function automatic logic [BAR_W-1:0] derive_mask(input logic [BAR_W-1:0] w);
    return {{2{w[BAR_W-3]}}, w[BAR_W-3:LOW_W], {LOW_W{1'b0}}};
  endfunction

  // Byte-lane and mask-limited merge of a write into the stored base.
  function automatic logic [BAR_W-1:0] be_merge(input logic [BAR_W-1:0] old_v,
                                                input logic [BAR_W-1:0] wdata,
                                                input logic [NBYTES-1:0] be,
                                                input logic [BAR_W-1:0] mask);
    logic [BAR_W-1:0] lane;
    logic [BAR_W-1:0] upd;
    for (int i = 0; i < NBYTES; i++) lane[8*i +: 8] = {8{be[i]}};
    upd = lane & mask;
    return (old_v & ~upd) | (wdata & upd);
  endfunction

  // Read value: base over bits 31:4, then prefetch, hardwired 0, type, space 0.
  function automatic logic [BAR_W-1:0] compose_read(input logic [BAR_W-1:0] base,
                                                    input bar_cfg_t cfg,
                                                    input logic en);
    logic [BAR_W-1:0] v;
    v = {base[BAR_W-1:LOW_W] & cfg.mask[BAR_W-1:LOW_W], cfg.pf, 1'b0, cfg.mtype, 1'b0};
    return en ? v : '0;
  endfunction

  function automatic logic addr_match(input logic [BAR_W-1:0] addr,
                                      input logic [BAR_W-1:0] base,
                                      input logic [BAR_W-1:0] mask);
    return ((addr ^ base) & mask) == '0;
  endfunction
endpackage

// File: rtl/bar_boot_cfg.sv
module bar_boot_cfg
  import bar_pkg::*;
#(
  parameter bit               IS_REG0   = 1'b0,
  parameter logic [BAR_W-1:0] REG0_MASK = 32'hFFFF_F000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_load,
  input  logic [BAR_W-1:0] boot_word,
  output bar_cfg_t         cfg_q,
  output logic             loaded_q
);
  bar_cfg_t cfg_d;

  generate
    if (IS_REG0) begin : g_reg0
      always_comb begin
        cfg_d.mask  = REG0_MASK & ~{{(BAR_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
        cfg_d.pf    = 1'b0;
        cfg_d.mtype = 1'b0;
        cfg_d.width = bw_code_e'(boot_word[BAR_W-1 -: 2]);
      end
    end else begin : g_regn
      always_comb begin
        cfg_d.mask  = derive_mask(boot_word);
        cfg_d.pf    = boot_word[3];
        cfg_d.mtype = boot_word[1];
        cfg_d.width = bw_code_e'(boot_word[BAR_W-1 -: 2]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{mask: '0, pf: 1'b0, mtype: 1'b0, width: BW_OFF};
      loaded_q <= 1'b0;
    end else if (boot_load) begin
      cfg_q    <= cfg_d;
      loaded_q <= 1'b1;
    end
  end

  assert_boot_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_load |=> (loaded_q && cfg_q.width == $past(boot_word[BAR_W-1 -: 2])));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_load |=> $stable(cfg_q));
endmodule

// File: rtl/bar_base_store.sv
module bar_base_store
  import bar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_fire,
  input  logic [NBYTES-1:0] be,
  input  logic [BAR_W-1:0]  wdata,
  input  logic [BAR_W-1:0]  mask,
  output logic [BAR_W-1:0]  base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (clr)     base_q <= '0;
    else if (wr_fire) base_q <= be_merge(base_q, wdata, be, mask);
  end

  assert_no_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !clr) |=> $stable(base_q));

  assert_base_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q & ~mask) == '0);

  assert_clear_on_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> base_q == '0);
endmodule

// File: rtl/bar_hit_decode.sv
module bar_hit_decode
  import bar_pkg::*;
(
  input  logic             en,
  input  logic [BAR_W-1:0] addr,
  input  logic [BAR_W-1:0] base,
  input  logic [BAR_W-1:0] mask,
  output logic             hit
);
  always_comb hit = en && addr_match(addr, base, mask);
endmodule

// File: rtl/bar_mem_region.sv
module bar_mem_region
  import bar_pkg::*;
#(
  parameter bit          IS_REG0   = 1'b0,
  parameter logic [31:0] REG0_MASK = 32'hFFFF_F000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_load,
  input  logic [31:0] boot_word,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] probe_addr,
  output logic        addr_hit,
  output logic        region_en,
  output logic [1:0]  bus_width
);
  bar_cfg_t          cfg_q;
  logic              loaded_q;
  logic [BAR_W-1:0]  base_q;
  logic              wr_fire;
  logic              boot_clr;

  bar_boot_cfg #(.IS_REG0(IS_REG0), .REG0_MASK(REG0_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_word(boot_word),
    .cfg_q(cfg_q), .loaded_q(loaded_q)
  );

  assign region_en = loaded_q && (cfg_q.width != BW_OFF);
  assign wr_fire   = cfg_we && region_en;
  assign boot_clr  = boot_load;
  assign bus_width = cfg_q.width;

  bar_base_store u_base (
    .clk(clk), .rst_n(rst_n), .clr(boot_clr), .wr_fire(wr_fire), .be(cfg_be),
    .wdata(cfg_wdata), .mask(cfg_q.mask), .base_q(base_q)
  );

  bar_hit_decode u_hit (
    .en(region_en), .addr(probe_addr), .base(base_q), .mask(cfg_q.mask), .hit(addr_hit)
  );

  assign cfg_rdata = compose_read(base_q, cfg_q, region_en);

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !region_en |-> (cfg_rdata == '0 && !addr_hit));

  assert_fixed_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2] == 1'b0 && cfg_rdata[0] == 1'b0);

  assert_hit_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (region_en && (((probe_addr ^ {cfg_rdata[31:4], 4'b0}) & cfg_q.mask) == '0)) |-> addr_hit);

  assert_width_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_width == 2'b00) |-> !region_en);

  generate
    if (IS_REG0) begin : g_r0_chk
      assert_reg0_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        region_en |-> cfg_rdata[3:1] == 3'b000);
    end
  endgenerate
endmodule

// File: tb/tb_bar_mem_region.sv
module tb_bar_mem_region;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_load = 1'b0;
  logic [31:0] boot_word = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] probe_addr = '0;
  logic [31:0] rd_a, rd_b;
  logic        hit_a, hit_b, en_a, en_b;
  logic [1:0]  bw_a, bw_b;
  logic        sel_b = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bar_mem_region #(.IS_REG0(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load && !sel_b), .boot_word(boot_word),
    .cfg_we(cfg_we && !sel_b), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a),
    .probe_addr(probe_addr), .addr_hit(hit_a), .region_en(en_a), .bus_width(bw_a)
  );

  bar_mem_region #(.IS_REG0(1'b1), .REG0_MASK(32'hFFFF_F000)) dut_r0 (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load && sel_b), .boot_word(boot_word),
    .cfg_we(cfg_we && sel_b), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b),
    .probe_addr(probe_addr), .addr_hit(hit_b), .region_en(en_b), .bus_width(bw_b)
  );

  typedef struct {
    bit          inst;
    logic [31:0] rdata;
    logic        hit;
    logic        en;
    logic [1:0]  bw;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event ev_chk;

  initial begin
    forever begin
      @(ev_chk);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [31:0] r; logic h, n; logic [1:0] w;
        e = exp_q.pop_front();
        r = e.inst ? rd_b : rd_a;
        h = e.inst ? hit_b : hit_a;
        n = e.inst ? en_b : en_a;
        w = e.inst ? bw_b : bw_a;
        n_tests++;
        if (r !== e.rdata || h !== e.hit || n !== e.en || w !== e.bw) begin
          n_fail++;
          $display("FAIL %s: rdata=%h hit=%b en=%b bw=%b expected rdata=%h hit=%b en=%b bw=%b",
                   e.tag, r, h, n, w, e.rdata, e.hit, e.en, e.bw);
        end
      end
    end
  end

  task automatic expect_out(input bit inst, input logic [31:0] rdata, input logic hit,
                            input logic en, input logic [1:0] bw, input string tag);
    exp_t e;
    #2;
    e.inst = inst; e.rdata = rdata; e.hit = hit; e.en = en; e.bw = bw; e.tag = tag;
    exp_q.push_back(e);
    ->ev_chk;
    #1;
  endtask

  task automatic do_boot(input bit inst, input logic [31:0] w);
    @(negedge clk);
    sel_b = inst; boot_word = w; boot_load = 1'b1;
    @(negedge clk);
    boot_load = 1'b0;
  endtask

  task automatic do_write(input bit inst, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    sel_b = inst; cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk);
    probe_addr = a;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet state after reset
    expect_out(0, 32'h0, 1'b0, 1'b0, 2'b00, "R1 reset state");
    // R4: write before any boot, probe at base 0, region still off
    do_write(0, 4'hF, 32'hFFFF_FFFF);
    set_addr(32'h0000_0000);
    expect_out(0, 32'h0, 1'b0, 1'b0, 2'b00, "R4 off before boot");
    // R2 R3 R7: width 32, mask FFFFF000, prefetch and type set
    do_boot(0, 32'hFFFF_F00A);
    expect_out(0, 32'h0000_000A, 1'b1, 1'b1, 2'b11, "R2 R3 R7 boot latch");
    // R6 R7: full write limited by mask
    do_write(0, 4'hF, 32'hFFFF_FFFF);
    expect_out(0, 32'hFFFF_F00A, 1'b0, 1'b1, 2'b11, "R6 R7 sizing write");
    // R6: only byte 2 written
    do_write(0, 4'b0100, 32'h0000_0000);
    expect_out(0, 32'hFF00_F00A, 1'b0, 1'b1, 2'b11, "R6 byte lane 2");
    // R6: only byte 3 written
    do_write(0, 4'b1000, 32'h1234_5678);
    expect_out(0, 32'h1200_F00A, 1'b0, 1'b1, 2'b11, "R6 byte lane 3");
    // R9: hit decode
    set_addr(32'h1200_F123);
    expect_out(0, 32'h1200_F00A, 1'b1, 1'b1, 2'b11, "R9 hit below mask boundary");
    set_addr(32'h1200_E000);
    expect_out(0, 32'h1200_F00A, 1'b0, 1'b1, 2'b11, "R9 miss bit 12");
    set_addr(32'h1300_F000);
    expect_out(0, 32'h1200_F00A, 1'b0, 1'b1, 2'b11, "R9 miss bit 24");
    // R10 R5 R3: reload width 8, bit 29 copied upward, base cleared
    set_addr(32'hFFFF_FFFF);
    do_boot(0, 32'h7FFF_0000);
    expect_out(0, 32'h0000_0000, 1'b0, 1'b1, 2'b01, "R10 R3 reload clears base");
    do_write(0, 4'hF, 32'hFFFF_FFFF);
    expect_out(0, 32'hFFFF_0000, 1'b1, 1'b1, 2'b01, "R5 mask top bits copy bit 29");
    // R5 R6: mask with gaps, width 16
    do_boot(0, 32'hA000_0FF0);
    do_write(0, 4'hF, 32'hFFFF_FFFF);
    expect_out(0, 32'hE000_0FF0, 1'b1, 1'b1, 2'b10, "R5 gapped mask");
    do_write(0, 4'b0001, 32'h0000_005A);
    expect_out(0, 32'hE000_0F50, 1'b0, 1'b1, 2'b10, "R6 byte 0 masked bits");
    // R4: width code 00 switches region off
    set_addr(32'h0000_0000);
    do_boot(0, 32'h3FFF_FFFF);
    expect_out(0, 32'h0, 1'b0, 1'b0, 2'b00, "R4 region disabled");
    // R8: first-register instance ignores boot mask and flags
    expect_out(1, 32'h0, 1'b0, 1'b0, 2'b00, "R1 reg0 reset state");
    do_boot(1, 32'hFFFF_FFFF);
    expect_out(1, 32'h0, 1'b1, 1'b1, 2'b11, "R8 reg0 flags zero");
    do_write(1, 4'hF, 32'hFFFF_FFFF);
    set_addr(32'hFFFF_F555);
    expect_out(1, 32'hFFFF_F000, 1'b1, 1'b1, 2'b11, "R8 reg0 fixed mask");
    set_addr(32'hFFFF_E555);
    expect_out(1, 32'hFFFF_F000, 1'b0, 1'b1, 2'b11, "R9 reg0 miss");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule